// File: doc/BRIEF.md
# I2C Target with Strap-Selected Address

This block is a synchronous I2C target that sits on a system clock. It passes SCL, SDA and an address strap pin through a short synchronizer, finds SCL edges, START, repeated START and STOP, and runs the byte-level protocol on those events. The target holds an eight-entry register file of bytes. A write transfer carries a pointer byte followed by any number of data bytes. A read transfer returns bytes starting at the current pointer. The target drives SDA only as an open-drain pull-down enable, so the surrounding pad logic pulls the line low while `sda_oe_o` is high.

The seven-bit target address is `1001 0xy`. The low pair `xy` comes from how the strap pin is wired: to ground, to the supply, to SDA or to SCL. The block works this out by watching the strap pin at every SCL and SDA edge. Each observation window starts at a START and closes when the address byte is complete.

The block has no data stream at its edge: it moves data only over the two-wire bus, so every pin is a plain level. A STOP that falls inside the same SCL-high interval as the START before it is not legal bus traffic. The block ignores such a STOP and carries on with the address phase.

Top module: `i2c_strap_target`

## Requirements
- R1: A transfer is START, seven address bits MSB first, then a direction bit in the least significant position (0 = write, 1 = read). When the address matches, `sda_oe_o` is 1 for the whole ninth SCL-high interval.
- R2: The two low address bits are 00 with the strap tied low, 01 with it tied high, 10 when it follows SDA and 11 when it follows SCL. This gives the addresses 0x48 to 0x4B. The choice is made from strap samples taken at every line edge between the START and the end of the address byte.
- R3: After an address that does not match, the target gives no acknowledge and keeps `sda_oe_o` at 0 until the next START or STOP. Data bytes sent in that transfer leave the register file unchanged.
- R4: In a write transfer, the first byte after the address loads the pointer from its low three bits; the upper five bits are ignored. Each later byte is stored at the pointer. Every such byte is acknowledged.
- R5: The pointer moves up by one after each byte stored and after each byte sent, and wraps from 7 to 0. The pointer keeps its value from one transfer to the next.
- R6: In a read transfer, the target sends the byte at the pointer MSB first: `sda_oe_o` is the inverse of the bit and changes only while SCL is low. It releases SDA during the ninth clock.
- R7: If the master pulls SDA low on the ninth clock of a read byte, the next byte follows. If the master leaves SDA high (NACK), the target stops driving until the next START or STOP.
- R8: A repeated START at any point starts a new address phase. Write transfers may follow each other with or without a STOP between them.
- R9: A STOP (SDA rising while SCL is high) at any point returns the target to idle with SDA released. A partly received byte is dropped.
- R10: A STOP inside the same SCL-high interval as the START before it is ignored, and the address phase continues.
- R11: After reset, SDA is released, all registers read 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 1 | Address strap pin (tied low, high, to SDA or to SCL) |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The assertions assume bus timing that is slow against the system clock. SCL must stay low for well over the three-cycle synchronizer latency. SDA must change only while SCL is low, apart from START and STOP. Under these conditions, every change of the target's drive lands inside an SCL-low interval. The bench builds each bit from six-cycle quarter periods, so the master changes data in the middle of the low phase. The target changes its output about three cycles after SCL falls, well before the next rising edge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } tgt_state_t;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_HIGH = 2'b01,
    STRAP_DATA = 2'b10,
    STRAP_CLK  = 2'b11
  } strap_class_t;

  // Observations of the strap pin since the last START
  typedef struct packed {
    logic seen_hi;
    logic seen_lo;
    logic data_diff;
    logic clk_diff;
  } strap_obs_t;

  function automatic strap_class_t classify(input strap_obs_t o);
    if (!o.seen_hi)        return STRAP_LOW;
    else if (!o.seen_lo)   return STRAP_HIGH;
    else if (!o.data_diff) return STRAP_DATA;
    else                   return STRAP_CLK;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic scl_s,
  output logic sda_s,
  output logic strap_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_edge,
  output logic start_p,
  output logic stop_p,
  output logic stop_cand,
  output logic start_in_high
);
  // bit order inside a stage: {strap, sda, scl}; bus idles high
  localparam logic [2:0] IDLE_LINES = 3'b011;

  logic [SYNC_STAGES-1:0][2:0] chain;
  logic [2:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= IDLE_LINES;
      last <= IDLE_LINES;
    end else begin
      chain[0] <= {strap_i, sda_i, scl_i};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[SYNC_STAGES-1];
    end
  end

  assign scl_s   = chain[SYNC_STAGES-1][0];
  assign sda_s   = chain[SYNC_STAGES-1][1];
  assign strap_s = chain[SYNC_STAGES-1][2];

  assign scl_rise = scl_s & ~last[0];
  assign scl_fall = ~scl_s & last[0];
  assign sda_edge = sda_s ^ last[1];

  assign start_p   = scl_s & last[0] & last[1] & ~sda_s;
  assign stop_cand = scl_s & last[0] & ~last[1] & sda_s;

  // set by a START, cleared once SCL goes low: a STOP in between is illegal
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_in_high <= 1'b0;
    else if (start_p)  start_in_high <= 1'b1;
    else if (!scl_s)   start_in_high <= 1'b0;
  end

  assign stop_p = stop_cand & ~start_in_high;

endmodule

// File: rtl/i2c_strap_sense.sv
module i2c_strap_sense
  import i2c_tgt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_s,
  input  logic         sda_s,
  input  logic         strap_s,
  input  logic         sample_en,
  input  logic         restart,
  output strap_class_t strap_class
);
  strap_obs_t obs;
  strap_obs_t fresh;

  always_comb begin
    fresh.seen_hi   = strap_s;
    fresh.seen_lo   = ~strap_s;
    fresh.data_diff = strap_s ^ sda_s;
    fresh.clk_diff  = strap_s ^ scl_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         obs <= '0;
    else if (restart)   obs <= fresh;
    else if (sample_en) obs <= obs | fresh;
  end

  assign strap_class = classify(obs);

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int REG_COUNT = 8,
  parameter int BYTE_W    = 8,
  localparam int PTR_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [REG_COUNT-1:0][BYTE_W-1:0] rd_vec;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_entry
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= '0;
      else if (we && waddr == PTR_W'(g))    q <= wdata;
    end
    assign rd_vec[g] = q;
  end

  assign rdata = rd_vec[raddr];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int          REG_COUNT  = 8,   // power of two
  parameter logic [4:0]  ADDR_FIXED = 5'b10010,
  localparam int         PTR_W      = $clog2(REG_COUNT),
  localparam int         BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  strap_class_t      strap_class,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output tgt_state_t        state,
  output logic [PTR_W-1:0]  ptr,
  output logic              rf_we,
  output logic [PTR_W-1:0]  rf_waddr,
  output logic [BYTE_W-1:0] rf_wdata
);
  localparam logic [3:0] BITS_DONE = 4'd8;

  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [3:0]        bit_cnt;
  logic              rd_dir;
  logic              ptr_phase;
  logic              got_nack;
  logic [6:0]        own_addr;

  assign own_addr = {ADDR_FIXED, logic'(strap_class[1]), logic'(strap_class[0])};

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(REG_COUNT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      bit_cnt   <= '0;
      rd_dir    <= 1'b0;
      ptr_phase <= 1'b0;
      got_nack  <= 1'b0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
    end else begin
      rf_we <= 1'b0;
      if (start_p) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_p) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE, ST_WAIT: ;
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BITS_DONE) begin
              if (rx_sh[BYTE_W-1:1] == own_addr) begin
                state  <= ST_ADDR_ACK;
                sda_oe <= 1'b1;
                rd_dir <= rx_sh[0];
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_dir) begin
                state  <= ST_RD;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                state     <= ST_WR;
                sda_oe    <= 1'b0;
                ptr_phase <= 1'b1;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BITS_DONE) begin
              state     <= ST_WR_ACK;
              sda_oe    <= 1'b1;
              ptr_phase <= 1'b0;
              if (ptr_phase) begin
                ptr <= rx_sh[PTR_W-1:0];
              end else begin
                rf_we    <= 1'b1;
                rf_waddr <= ptr;
                rf_wdata <= rx_sh;
                ptr      <= ptr_next(ptr);
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              state   <= ST_WR;
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == BITS_DONE) begin
                state  <= ST_RD_ACK;
                sda_oe <= 1'b0;
                ptr    <= ptr_next(ptr);
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              got_nack <= sda_s;
            end else if (scl_fall) begin
              if (got_nack) begin
                state <= ST_WAIT;
              end else begin
                state   <= ST_RD;
                bit_cnt <= '0;
                tx_sh   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int         REG_COUNT   = 8,
  parameter logic [4:0] ADDR_FIXED  = 5'b10010,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(REG_COUNT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic sda_oe_o
);
  logic         scl_s, sda_s, strap_s;
  logic         scl_rise, scl_fall, sda_edge;
  logic         start_p, stop_p, stop_cand, start_in_high;
  strap_class_t strap_class;
  tgt_state_t   eng_state;
  logic [PTR_W-1:0] ptr;
  logic             rf_we;
  logic [PTR_W-1:0] rf_waddr;
  logic [7:0]       rf_wdata;
  logic [7:0]       rf_rdata;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .scl_i(scl_i), .sda_i(sda_i), .strap_i(strap_i),
    .scl_s(scl_s), .sda_s(sda_s), .strap_s(strap_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_edge(sda_edge),
    .start_p(start_p), .stop_p(stop_p),
    .stop_cand(stop_cand), .start_in_high(start_in_high)
  );

  i2c_strap_sense u_strap (
    .clk(clk), .rst_n(rst_n),
    .scl_s(scl_s), .sda_s(sda_s), .strap_s(strap_s),
    .sample_en(scl_rise | scl_fall | sda_edge),
    .restart(start_p),
    .strap_class(strap_class)
  );

  i2c_reg_bank #(.REG_COUNT(REG_COUNT), .BYTE_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(ptr), .rdata(rf_rdata)
  );

  i2c_tgt_engine #(.REG_COUNT(REG_COUNT), .ADDR_FIXED(ADDR_FIXED)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p),
    .strap_class(strap_class), .rd_data(rf_rdata),
    .sda_oe(sda_oe_o), .state(eng_state), .ptr(ptr),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int  REG_COUNT = 8,
  localparam int PTR_W     = $clog2(REG_COUNT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             start_p,
  input logic             stop_p,
  input logic             stop_cand,
  input logic             start_in_high,
  input tgt_state_t       eng_state,
  input logic [PTR_W-1:0] ptr,
  input logic             rf_we,
  input logic [PTR_W-1:0] rf_waddr
);

  AST_ACK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_state == ST_ADDR_ACK || eng_state == ST_WR_ACK) && scl_i) |-> sda_oe_o); // R1

  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == ST_WAIT) |-> !sda_oe_o); // R3

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr == PTR_W'(REG_COUNT - 1)) |-> (ptr == '0)); // R5

  AST_OE_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe_o != $past(sda_oe_o)) && !$past(start_p) && !$past(stop_p)) |-> !scl_i); // R6

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (eng_state == ST_ADDR && !sda_oe_o)); // R8

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (eng_state == ST_IDLE && !sda_oe_o)); // R9

  AST_EARLY_STOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cand && start_in_high && !start_p) |=> (eng_state != ST_IDLE)); // R10

endmodule

bind i2c_strap_target i2c_strap_target_chk #(.REG_COUNT(REG_COUNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .start_p(start_p), .stop_p(stop_p),
  .stop_cand(stop_cand), .start_in_high(start_in_high),
  .eng_state(eng_state), .ptr(ptr), .rf_we(rf_we), .rf_waddr(rf_waddr)
);

// File: tb/i2c_strap_target_tb_top.sv
module i2c_strap_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;     // quarter SCL period in system clocks
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_rel = 1'b1;
  logic [1:0] strap_mode = 2'd0;
  logic sda_oe;
  logic sda_bus;
  logic strap_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_regs [8];
  logic [2:0] exp_ptr;
  logic [7:0] wbuf [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda_bus = sda_rel & ~sda_oe;

  always_comb begin
    case (strap_mode)
      2'd0:    strap_w = 1'b0;
      2'd1:    strap_w = 1'b1;
      2'd2:    strap_w = sda_bus;
      default: strap_w = scl_m;
    endcase
  end

  i2c_strap_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap_w), .sda_oe_o(sda_oe)
  );

  function automatic logic [6:0] addr_for(input logic [1:0] m);
    return {5'b10010, m};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_rel = 1'b1; wcyc(Q);
    scl_m = 1'b1;   wcyc(2 * Q);
    sda_rel = 1'b0; wcyc(2 * Q);
    scl_m = 1'b0;   wcyc(Q);
  endtask

  task automatic bus_stop();
    sda_rel = 1'b0; wcyc(Q);
    scl_m = 1'b1;   wcyc(2 * Q);
    sda_rel = 1'b1; wcyc(2 * Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda_rel = b;  wcyc(Q);
    scl_m = 1'b1; wcyc(Q);
    seen = sda_bus; wcyc(Q);
    scl_m = 1'b0; wcyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~master_ack, s);
  endtask

  function automatic logic [2:0] nxt(input logic [2:0] p);
    return p + 3'd1;
  endfunction

  // write: address, pointer byte, n data bytes from wbuf
  task automatic do_write(input logic [7:0] cmd, input int n, input bit with_stop);
    logic a;
    bus_start();
    send_byte({addr_for(strap_mode), 1'b0}, a);
    chk("R1 write address ack", a, 1'b1);
    send_byte(cmd, a);
    chk("R4 pointer byte ack", a, 1'b1);
    exp_ptr = cmd[2:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk("R4 data byte ack", a, 1'b1);
      exp_regs[exp_ptr] = wbuf[i];
      exp_ptr = nxt(exp_ptr);
    end
    if (with_stop) bus_stop();
  endtask

  task automatic do_read(input logic [7:0] cmd, input int n, input string tag);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({addr_for(strap_mode), 1'b0}, a);
    chk("R2 strap address ack", a, 1'b1);
    send_byte(cmd, a);
    exp_ptr = cmd[2:0];
    bus_start();
    send_byte({addr_for(strap_mode), 1'b1}, a);
    chk("R6 read address ack", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(tag, d, exp_regs[exp_ptr]);
      exp_ptr = nxt(exp_ptr);
    end
    bus_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    logic s;
    int unsigned seed_v;
    seed_v = $urandom(32'd91731);
    for (int i = 0; i < 8; i++) exp_regs[i] = 8'h00;
    exp_ptr = 3'd0;

    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    chk("R11 SDA released after reset", sda_oe, 1'b0);

    // R11: register file reads zero after reset
    strap_mode = 2'd1;
    do_read(8'h00, 8, "R11 reset register value");

    // per strap wiring: mismatch, write, read back (R2, R3, R4, R6)
    for (int m = 0; m < 4; m++) begin
      strap_mode = 2'(m);
      bus_start();
      send_byte({addr_for(2'(m + 1)), 1'b0}, a);
      chk("R3 mismatched address gives no ack", a, 1'b0);
      send_byte(8'h01, a);
      chk("R3 no ack after mismatch", a, 1'b0);
      send_byte(8'hEE, a);
      chk("R3 no ack for data after mismatch", a, 1'b0);
      bus_stop();
      for (int i = 0; i < 3; i++) wbuf[i] = 8'(($urandom % 255) + 1);
      do_write({5'($urandom), 3'(m * 2)}, 3, 1'b1);
      do_read(8'(m * 2), 3, "R2 strap readback data");
    end

    // R5: pointer wrap on write and read
    strap_mode = 2'd2;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(8'h06, 4, 1'b1);
    do_read(8'h06, 4, "R5 wrapped data");

    // R8: two writes joined by a repeated START
    strap_mode = 2'd3;
    wbuf[0] = 8'h5A;
    do_write(8'h02, 1, 1'b0);
    wbuf[0] = 8'h3C;
    do_write(8'h04, 1, 1'b1);
    do_read(8'h02, 1, "R8 first chained write");
    do_read(8'h04, 1, "R8 second chained write");

    // R7: master NACK ends the read; pointer kept (R5)
    strap_mode = 2'd0;
    bus_start();
    send_byte({addr_for(2'd0), 1'b0}, a);
    send_byte(8'h03, a);
    bus_start();
    send_byte({addr_for(2'd0), 1'b1}, a);
    recv_byte(1'b0, d);
    chk("R7 byte before NACK", d, exp_regs[3]);
    recv_byte(1'b0, d);
    chk("R7 bus released after NACK", d, 8'hFF);
    chk("R7 no drive after NACK", sda_oe, 1'b0);
    bus_stop();
    bus_start();
    send_byte({addr_for(2'd0), 1'b1}, a);
    chk("R5 read without pointer ack", a, 1'b1);
    recv_byte(1'b0, d);
    chk("R5 pointer advanced by read", d, exp_regs[4]);
    bus_stop();

    // R10: STOP inside the START's SCL-high interval is ignored
    strap_mode = 2'd3;
    sda_rel = 1'b1; wcyc(Q);
    scl_m = 1'b1;   wcyc(2 * Q);
    sda_rel = 1'b0; wcyc(Q);
    sda_rel = 1'b1; wcyc(Q);
    scl_m = 1'b0;   wcyc(Q);
    send_byte({addr_for(2'd3), 1'b0}, a);
    chk("R10 address after illegal STOP acked", a, 1'b1);
    send_byte(8'h05, a);
    send_byte(8'h77, a);
    chk("R10 data after illegal STOP acked", a, 1'b1);
    exp_regs[5] = 8'h77;
    bus_stop();
    do_read(8'h05, 1, "R10 data stored");

    // R9: STOP in the middle of a data byte drops it
    strap_mode = 2'd1;
    bus_start();
    send_byte({addr_for(2'd1), 1'b0}, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
    bus_stop();
    chk("R9 SDA released after STOP", sda_oe, 1'b0);
    do_read(8'h00, 1, "R9 partial byte dropped");

    // random transfers
    for (int k = 0; k < 10; k++) begin
      int n;
      logic [7:0] cmd;
      strap_mode = 2'($urandom);
      n = int'($urandom % 5) + 1;
      cmd = 8'($urandom);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(cmd, n, 1'b1);
      do_read({5'd0, cmd[2:0]}, n, "R4 random write readback");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule